// File: doc/BRIEF.md
# Free-Running Timer with Match Channels

This block is an operating-system timer. A 32-bit up-counter advances by one on every cycle in which the slow timer tick enable is high. It wraps from all ones back to zero. Four compare channels each hold a match value. When the counter moves onto a channel's value, that channel's sticky status bit is set. A per-channel enable bit then gates the status bit onto that channel's interrupt line, and one combined line ORs the four channel lines.

Software reaches the block through a simple synchronous register bus. Through it, software can load the counter, program the match values and the enable bits, and clear status bits. The usual way to arm a channel is as follows: set its enable bit, read the counter, and write the counter plus a delta into that channel's match value. A match is only detected when the counter moves. A delta of two counts or fewer can therefore be overtaken before the match value is written, so software should treat such a delta as unsafe.

Top module: `ost_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero: counter, enable, status and all match values. The interrupt outputs are low.
- R2: With `tick_en` high and no counter write, the counter increases by one on each clock edge. It wraps from 0xFFFFFFFF to 0.
- R3: With `tick_en` low and no counter write, the counter holds its value.
- R4: A bus write to address 0 loads the counter with `bus_wdata` on that edge. The load takes priority over a tick in the same cycle.
- R5: Status bit i (address 2, bit i) is set on the same edge that the counter takes a value equal to match register i (address 4+i). This holds whether the counter got there by a tick or by a load.
- R6: A status bit stays set until software clears it. Further ticks do not clear it.
- R7: Output `chan_irq[i]` is status bit i ANDed with enable bit i (address 1, bit i). Output `irq` is the OR of all four `chan_irq` bits.
- R8: A bus write to the status register clears each status bit written as 0 and leaves each bit written as 1 unchanged. Writing zero clears all bits.
- R9: A status bit is not set while the counter does not move. Writing a match value equal to the current count sets nothing.
- R10: If a match and a clearing status write hit the same bit on the same edge, the bit ends up set.
- R11: Register map: address 0 is the counter, 1 is enable in bits 3:0, 2 is status in bits 3:0, 3 reads zero, and 4 to 7 are match 0 to 3. Unused bits read zero. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick enable; the counter advances on edges where it is high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| chan_irq | output | 4 | Per-channel gated interrupt |
| irq | output | 1 | OR of all channel interrupts |

## Verification
The hardest case to reach from the ports is a match landing on the same edge as a software clear of that same status bit. To reach it, the bench programs a match value exactly one count ahead. It then issues the status write of zero in the one cycle that `tick_en` is high. A second directed case makes a counter load land on a match value, so that a load with no tick must still fire the channel. Wrap-around is reached by loading the counter just below all ones. Random arming with small deltas then mixes overlapping channels, enable changes and partial clears.

// File: rtl/ost_pkg.sv
package ost_pkg;
    localparam int CNT_W  = 32;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_MATCH0 = 3'd4;

    typedef logic [CNT_W-1:0] count_t;
    typedef logic [NUM_CH-1:0] chmask_t;

    // decoded write strobes for one bus cycle
    typedef struct packed {
        logic    count;
        logic    enable;
        logic    status;
        chmask_t match;
    } wr_strobe_t;

    function automatic logic is_match_addr(input logic [ADDR_W-1:0] a, input int ch);
        return a == ADDR_W'(int'(ADR_MATCH0) + ch);
    endfunction

    function automatic count_t widen_mask(input chmask_t m);
        return count_t'(m);
    endfunction
endpackage

// File: rtl/ost_counter.sv
module ost_counter
    import ost_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick_en,
    input  logic   load,
    input  count_t load_val,
    output count_t cnt,
    output count_t cnt_next,
    output logic   cnt_upd
);
    always_comb begin
        cnt_upd  = load | tick_en;
        cnt_next = load ? load_val : cnt + count_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (cnt_upd) cnt <= cnt_next;
    end

    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !load) |=> cnt == $past(cnt) + count_t'(1));
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !load) |=> $stable(cnt));
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/ost_match_chan.sv
module ost_match_chan
    import ost_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_match,
    input  count_t wdata,
    input  logic   cnt_upd,
    input  count_t cnt_next,
    input  logic   wr_status,
    input  logic   status_keep,
    input  logic   en,
    output count_t match_val,
    output logic   flag,
    output logic   irq_out
);
    logic hit;
    logic clr;

    always_comb begin
        hit     = cnt_upd && (cnt_next == match_val);
        clr     = wr_status && !status_keep;
        irq_out = flag & en;
    end

    always_ff @(posedge clk) begin
        if (rst)           match_val <= '0;
        else if (wr_match) match_val <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    a_r5_set_on_hit: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag);
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(cnt_upd));
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hit && clr) |=> flag);
endmodule

// File: rtl/ost_regbank.sv
module ost_regbank
    import ost_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  count_t                         bus_wdata,
    input  count_t                         cnt,
    input  chmask_t                        status,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   match_vals,
    output wr_strobe_t                     wr,
    output chmask_t                        enable,
    output count_t                         rdata
);
    logic   rd;
    count_t rd_mux;

    always_comb begin
        rd           = bus_sel && !bus_wr;
        wr.count     = bus_sel && bus_wr && (bus_addr == ADR_COUNT);
        wr.enable    = bus_sel && bus_wr && (bus_addr == ADR_ENABLE);
        wr.status    = bus_sel && bus_wr && (bus_addr == ADR_STATUS);
        for (int i = 0; i < NUM_CH; i++)
            wr.match[i] = bus_sel && bus_wr && is_match_addr(bus_addr, i);
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADR_COUNT:  rd_mux = cnt;
            ADR_ENABLE: rd_mux = widen_mask(enable);
            ADR_STATUS: rd_mux = widen_mask(status);
            default: begin
                for (int i = 0; i < NUM_CH; i++)
                    if (is_match_addr(bus_addr, i)) rd_mux = match_vals[i];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            enable <= '0;
        else if (wr.enable) enable <= bus_wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));
    a_r11_one_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr.count, wr.enable, wr.status, wr.match}));
endmodule

// File: rtl/ost_timer.sv
module ost_timer
    import ost_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] chan_irq,
    output logic              irq
);
    wr_strobe_t                   wr;
    chmask_t                      enable;
    chmask_t                      status;
    count_t                       cnt;
    count_t                       cnt_next;
    logic                         cnt_upd;
    logic [NUM_CH-1:0][CNT_W-1:0] match_vals;

    ost_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .load     (wr.count),
        .load_val (bus_wdata),
        .cnt      (cnt),
        .cnt_next (cnt_next),
        .cnt_upd  (cnt_upd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        ost_match_chan u_chan (
            .clk         (clk),
            .rst         (rst),
            .wr_match    (wr.match[g]),
            .wdata       (bus_wdata),
            .cnt_upd     (cnt_upd),
            .cnt_next    (cnt_next),
            .wr_status   (wr.status),
            .status_keep (bus_wdata[g]),
            .en          (enable[g]),
            .match_val   (match_vals[g]),
            .flag        (status[g]),
            .irq_out     (chan_irq[g])
        );
    end

    ost_regbank u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cnt        (cnt),
        .status     (status),
        .match_vals (match_vals),
        .wr         (wr),
        .enable     (enable),
        .rdata      (bus_rdata)
    );

    assign irq = |chan_irq;

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(status & enable)));
    a_r7_irq_any: assert property (@(posedge clk) disable iff (rst)
        (|(status & enable)) |-> irq);
endmodule

// File: tb/ost_timer_tb.sv
`timescale 1ns/1ps
module ost_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  chan_irq;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_cnt;
    logic [31:0] m_match [4];
    logic [3:0]  m_st;
    logic [3:0]  m_en;

    always #2.5 clk = ~clk;

    ost_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .chan_irq(chan_irq), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_hits(input logic [31:0] v);
        logic [3:0] h = '0;
        for (int i = 0; i < 4; i++) if (m_match[i] == v) h[i] = 1'b1;
        return h;
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d, input logic t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            m_cnt = m_cnt + 1;
            m_st = m_st | model_hits(m_cnt);
        end
    endtask

    task automatic set_count(input logic [31:0] v);
        bus_write(3'd0, v, 1'b0);
        m_cnt = v;
        m_st = m_st | model_hits(v);
    endtask

    task automatic set_match(input int ch, input logic [31:0] v);
        bus_write(3'(4 + ch), v, 1'b0);
        m_match[ch] = v;
    endtask

    task automatic set_enable(input logic [3:0] v);
        bus_write(3'd1, {28'd0, v}, 1'b0);
        m_en = v;
    endtask

    task automatic write_status(input logic [3:0] v);
        bus_write(3'd2, {28'hFFFFFFF, v}, 1'b0);
        m_st = m_st & v;
    endtask

    task automatic check_state(input string req);
        logic [31:0] d;
        bus_read(3'd2, d);
        chk({req, " status"}, d, {28'd0, m_st});
        chk({req, " chan_irq"}, {28'd0, chan_irq}, {28'd0, m_st & m_en});
        chk({req, " irq"}, {31'd0, irq}, {31'd0, |(m_st & m_en)});
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5eed_0101));
        m_cnt = '0; m_st = '0; m_en = '0;
        for (int i = 0; i < 4; i++) m_match[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R11 register map
        for (int a = 0; a < 8; a++) begin
            bus_read(3'(a), d);
            chk("R1 reset reg", d, 32'd0);
        end
        chk("R1 reset irq", {27'd0, chan_irq, irq}, 32'd0);

        // R4 load, R11 read back
        set_count(32'd100);
        bus_read(3'd0, d); chk("R4 load", d, 32'd100);
        // R4 load beats a tick in the same cycle
        bus_write(3'd0, 32'd500, 1'b1); m_cnt = 32'd500;
        bus_read(3'd0, d); chk("R4 load priority", d, 32'd500);
        // R11 read data holds after the strobe
        repeat (3) @(negedge clk);
        chk("R11 rdata hold", bus_rdata, 32'd500);

        // R2 increment
        ticks(5);
        bus_read(3'd0, d); chk("R2 increment", d, 32'd505);
        // R3 hold
        repeat (10) @(negedge clk);
        bus_read(3'd0, d); chk("R3 hold", d, 32'd505);
        // R2 wrap
        set_count(32'hFFFF_FFFE);
        ticks(3);
        bus_read(3'd0, d); chk("R2 wrap", d, 32'd1);

        // R5 arm channel 0 with delta 3
        set_enable(4'b0001);
        bus_read(3'd0, d);
        set_match(0, d + 32'd3);
        bus_read(3'd4, d); chk("R11 match0 readback", d, m_cnt + 32'd3);
        ticks(2);
        check_state("R5 before match");
        ticks(1);
        check_state("R5 on match");
        chk("R7 irq ch0", {28'd0, chan_irq}, 32'd1);
        // R6 sticky
        ticks(5);
        check_state("R6 sticky");

        // R7 disabled channel sets status but no irq
        set_match(1, m_cnt + 32'd1);
        ticks(1);
        check_state("R7 masked ch1");
        chk("R7 ch1 masked", {31'd0, chan_irq[1]}, 32'd0);

        // R8 partial clear (keep bit0, clear bit1)
        write_status(4'b1101);
        check_state("R8 partial clear");
        write_status(4'b0000);
        check_state("R8 clear all");
        set_enable(4'b0000);

        // R9 match equal to current count sets nothing
        set_match(2, m_cnt);
        repeat (4) @(negedge clk);
        check_state("R9 no move no set");
        // R5 load onto a match value
        set_match(3, 32'h0000_ABCD);
        set_count(32'h0000_ABCD);
        check_state("R5 load hit");
        write_status(4'b0000);

        // R10 set wins over clear in the same cycle
        set_enable(4'b0100);
        set_match(2, m_cnt + 32'd1);
        bus_write(3'd2, 32'd0, 1'b1);
        m_cnt = m_cnt + 1;
        m_st = model_hits(m_cnt);
        check_state("R10 set wins");
        chk("R10 bit2", {31'd0, chan_irq[2]}, 32'd1);
        write_status(4'b0000);

        // random arming with small deltas
        for (int it = 0; it < 60; it++) begin
            int ch;
            int op;
            ch = int'($urandom % 4);
            op = int'($urandom % 4);
            case (op)
                0: set_match(ch, m_cnt + 32'(1 + $urandom % 6));
                1: set_enable(4'($urandom));
                2: write_status(4'($urandom));
                default: ticks(int'($urandom % 7));
            endcase
            check_state("R5 R7 random");
        end
        bus_read(3'd0, d); chk("R2 random count", d, m_cnt);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule